// File: doc/BRIEF.md
# APB Transfer Protocol Monitor

This block is a passive, synthesizable observer that sits beside an APB bus. It drives nothing on the bus. It watches the bus signals and the manager's read-data capture strobe. It checks the two-phase rule: a SETUP cycle always precedes ACCESS, and ACCESS is held for as long as the subordinate keeps the ready input low. It also checks that address and direction stay put for the whole transfer, and that read data is only captured on a ready cycle. Any rule break sets a sticky error flag that holds until reset.

For every transfer that completes, the monitor reports how many ACCESS cycles were sampled with ready low. The full transfer length is two cycles plus that wait count. The monitor also sorts each completed transfer into one of four latency bins: zero, one, two, or three-or-more waits. A separate counter records each time two back-to-back transfers have different wait counts, because mixed latency is the case that exposes managers which finish on a fixed cycle count.

All outputs are registered. A violation sampled at a clock edge shows up on its flag after that edge. A transfer that completes at an edge reports its wait count during the next cycle, with a one-cycle valid pulse.

Top module: `apb_xfer_monitor`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, every error flag is 0, every counter is 0 and the valid pulse is 0.
- R2: A transfer starts in a cycle with select high that does not follow a non-completing select cycle. If enable is already high in that starting cycle, the missing-setup flag is set.
- R3: An ACCESS cycle (select and enable high) sampled with ready low must be followed by another ACCESS cycle. Otherwise the premature-completion flag is set.
- R4: A capture pulse while write is 0 is legal only in a cycle with select, enable and ready all high; any other such pulse sets the capture flag. A capture pulse while write is 1 is ignored.
- R5: A change of address between cycles of the same transfer sets the address-stability flag.
- R6: A change of the write signal between cycles of the same transfer sets the control-stability flag.
- R7: A transfer completes at a cycle with select, enable and ready high. In the next cycle the valid pulse is high for exactly one cycle, and the wait-count output equals the number of that transfer's ACCESS cycles sampled with ready low, saturating at all-ones.
- R8: Each completed transfer adds one to exactly one bin: zero waits, one wait, two waits, or three or more waits.
- R9: A transfer is adjacent to the previous one when its first cycle is the cycle right after the previous completion. The mixed-latency counter increments when an adjacent transfer completes with a wait count different from the previous transfer's.
- R10: Error flags stay set until reset. Every histogram and mixed-latency counter saturates at all-ones.
- R11: Cycles with select low never complete a transfer and never change a counter, whatever enable, ready and a write-side capture do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Peripheral select |
| enable | input | 1 | Access-phase enable |
| write | input | 1 | Transfer direction, 1 = write |
| addr | input | ADDR_W | Transfer address |
| ready | input | 1 | Subordinate ready |
| capture | input | 1 | Manager read-data capture strobe |
| errMissingSetup | output | 1 | Sticky: ACCESS entered without SETUP |
| errPrematureDone | output | 1 | Sticky: ACCESS left while ready was low |
| errCaptureNoReady | output | 1 | Sticky: read capture outside a ready cycle |
| errAddrMoved | output | 1 | Sticky: address changed inside a transfer |
| errCtrlMoved | output | 1 | Sticky: write changed inside a transfer |
| waitCount | output | WAIT_W | Wait count of the last completed transfer |
| waitValid | output | 1 | One-cycle pulse qualifying waitCount |
| histZero | output | CNT_W | Transfers with no wait |
| histOne | output | CNT_W | Transfers with one wait |
| histTwo | output | CNT_W | Transfers with two waits |
| histMany | output | CNT_W | Transfers with three or more waits |
| mixedCount | output | CNT_W | Adjacent transfers with differing wait count |

## Verification
The embedded properties assume the manager's signals are settled at each sampling edge and that the capture strobe is driven only by the manager under observation. The bench changes every input just after the falling edge, so each rising edge sees a clean value. The properties also take the bus as single-manager, where select alone marks a transfer. The bench therefore builds transfers only from whole SETUP, ACCESS and wait cycles, separated by idle or back-to-back boundaries. It breaks each rule once, on purpose, in a phase of its own.

// File: rtl/apb_mon_pkg.sv
`timescale 1ns/1ps
package apb_mon_pkg;
  // Strobes from the phase tracker to the measurement datapath.
  typedef struct packed {
    logic start;     // first cycle of a new transfer
    logic waitTick;  // ACCESS cycle sampled with ready low
    logic done;      // completing ACCESS cycle
  } monStrobe_t;
endpackage

// File: rtl/apb_mon_ctrl.sv
`timescale 1ns/1ps
module apb_mon_ctrl
  import apb_mon_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              enable,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ready,
  input  logic              capture,
  output monStrobe_t        st,
  output logic              errSetup,
  output logic              errPremature,
  output logic              errCapture,
  output logic              errAddr,
  output logic              errCtrl
);
  logic              inXfer;       // previous cycle was a non-completing select cycle
  logic              pendingWait;  // previous cycle was ACCESS with ready low
  logic [ADDR_W-1:0] heldAddr;
  logic              heldWrite;

  logic accessPhase, completeNow, startNow;
  logic setupViol, prematureViol, captureViol, addrViol, ctrlViol;

  always_comb begin
    accessPhase   = sel && enable;
    completeNow   = accessPhase && ready;
    startNow      = sel && !inXfer;
    st.start      = startNow;
    st.waitTick   = accessPhase && !ready;
    st.done       = completeNow;
    setupViol     = startNow && enable;
    prematureViol = pendingWait && !accessPhase;
    captureViol   = capture && !write && !completeNow;
    addrViol      = sel && inXfer && (addr != heldAddr);
    ctrlViol      = sel && inXfer && (write != heldWrite);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inXfer      <= 1'b0;
      pendingWait <= 1'b0;
      heldAddr    <= '0;
      heldWrite   <= 1'b0;
    end else begin
      inXfer      <= sel && !completeNow;
      pendingWait <= accessPhase && !ready;
      if (sel) begin
        heldAddr  <= addr;
        heldWrite <= write;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errSetup     <= 1'b0;
      errPremature <= 1'b0;
      errCapture   <= 1'b0;
      errAddr      <= 1'b0;
      errCtrl      <= 1'b0;
    end else begin
      errSetup     <= errSetup     | setupViol;
      errPremature <= errPremature | prematureViol;
      errCapture   <= errCapture   | captureViol;
      errAddr      <= errAddr      | addrViol;
      errCtrl      <= errCtrl      | ctrlViol;
    end
  end

  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (sel && !inXfer && enable) |=> errSetup); // R2
  AST_HOLD_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (sel && enable && !ready) ##1 !(sel && enable) |=> errPremature); // R3
  AST_CAPTURE_READY: assert property (@(posedge clk) disable iff (!rstN)
    (capture && !write && !(sel && enable && ready)) |=> errCapture); // R4
  AST_ADDR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errAddr |=> errAddr); // R10
  AST_CTRL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errCtrl |=> errCtrl); // R10
endmodule

// File: rtl/apb_mon_dp.sv
`timescale 1ns/1ps
module apb_mon_dp
  import apb_mon_pkg::*;
#(
  parameter int WAIT_W  = 8,
  parameter int CNT_W   = 16,
  parameter int MANY_AT = 3
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  monStrobe_t                      st,
  output logic [WAIT_W-1:0]               waitCount,
  output logic                            waitValid,
  output logic [MANY_AT:0][CNT_W-1:0]     histCnt,
  output logic [CNT_W-1:0]                mixedCnt
);
  localparam int NUM_BINS = MANY_AT + 1;
  localparam int BIN_W    = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1;
  localparam logic [WAIT_W-1:0] WAIT_MAX = '1;
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

  logic [WAIT_W-1:0] waitCnt;   // waits of the transfer in flight
  logic [WAIT_W-1:0] lastWait;  // waits of the last completed transfer
  logic              justDone;  // previous cycle completed a transfer
  logic              chainReg;  // current transfer began right after a completion

  logic [WAIT_W-1:0] baseWait;
  logic              chainNow;
  logic [BIN_W-1:0]  binSel;

  always_comb begin
    baseWait = st.start ? '0 : waitCnt;
    chainNow = st.start ? justDone : chainReg;
    if (baseWait >= WAIT_W'(MANY_AT)) binSel = BIN_W'(MANY_AT);
    else                              binSel = BIN_W'(baseWait);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt   <= '0;
      lastWait  <= '0;
      justDone  <= 1'b0;
      chainReg  <= 1'b0;
      waitCount <= '0;
      waitValid <= 1'b0;
      mixedCnt  <= '0;
    end else begin
      justDone  <= st.done;
      waitValid <= st.done;
      if (st.start) chainReg <= justDone;
      if (st.done) begin
        waitCnt   <= '0;
        waitCount <= baseWait;
        lastWait  <= baseWait;
        if (chainNow && (baseWait != lastWait) && (mixedCnt != CNT_MAX))
          mixedCnt <= mixedCnt + 1'b1;
      end else if (st.waitTick) begin
        waitCnt <= (baseWait == WAIT_MAX) ? baseWait : baseWait + 1'b1;
      end else begin
        waitCnt <= baseWait;
      end
    end
  end

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        histCnt[b] <= '0;
      else if (st.done && (binSel == BIN_W'(b)) && (histCnt[b] != CNT_MAX))
        histCnt[b] <= histCnt[b] + 1'b1;
    end
  end

  AST_HIST_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !st.done |=> $stable(histCnt)); // R8
  AST_MIXED_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !st.done |=> $stable(mixedCnt)); // R9
  AST_MIXED_NO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (mixedCnt >= $past(mixedCnt))); // R10
  AST_VALID_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (st.done && !st.start && waitCnt == '0) |=> (waitValid && waitCount == '0)); // R7
endmodule

// File: rtl/apb_xfer_monitor.sv
`timescale 1ns/1ps
module apb_xfer_monitor
  import apb_mon_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WAIT_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              enable,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ready,
  input  logic              capture,
  output logic              errMissingSetup,
  output logic              errPrematureDone,
  output logic              errCaptureNoReady,
  output logic              errAddrMoved,
  output logic              errCtrlMoved,
  output logic [WAIT_W-1:0] waitCount,
  output logic              waitValid,
  output logic [CNT_W-1:0]  histZero,
  output logic [CNT_W-1:0]  histOne,
  output logic [CNT_W-1:0]  histTwo,
  output logic [CNT_W-1:0]  histMany,
  output logic [CNT_W-1:0]  mixedCount
);
  localparam int MANY_AT = 3;

  monStrobe_t                      strobes;
  logic [MANY_AT:0][CNT_W-1:0]     histCnt;

  apb_mon_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sel(sel), .enable(enable), .write(write),
    .addr(addr), .ready(ready), .capture(capture), .st(strobes),
    .errSetup(errMissingSetup), .errPremature(errPrematureDone),
    .errCapture(errCaptureNoReady), .errAddr(errAddrMoved), .errCtrl(errCtrlMoved)
  );

  apb_mon_dp #(.WAIT_W(WAIT_W), .CNT_W(CNT_W), .MANY_AT(MANY_AT)) u_dp (
    .clk(clk), .rstN(rstN), .st(strobes), .waitCount(waitCount),
    .waitValid(waitValid), .histCnt(histCnt), .mixedCnt(mixedCount)
  );

  assign histZero = histCnt[0];
  assign histOne  = histCnt[1];
  assign histTwo  = histCnt[2];
  assign histMany = histCnt[3];
endmodule

// File: tb/test_apb_xfer_monitor.sv
`timescale 1ns/1ps
module test_apb_xfer_monitor;
  localparam int ADDR_W = 12;
  localparam int WAIT_W = 8;
  localparam int CNT_W  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sel = 1'b0, enable = 1'b0, write = 1'b0, ready = 1'b0, capture = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic errMissingSetup, errPrematureDone, errCaptureNoReady, errAddrMoved, errCtrlMoved;
  logic [WAIT_W-1:0] waitCount;
  logic waitValid;
  logic [CNT_W-1:0] histZero, histOne, histTwo, histMany, mixedCount;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int expQ[$];

  always #5 clk = ~clk;

  apb_xfer_monitor #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .CNT_W(CNT_W)) i_apb_xfer_monitor (
    .clk(clk), .rstN(rstN), .sel(sel), .enable(enable), .write(write), .addr(addr),
    .ready(ready), .capture(capture), .errMissingSetup(errMissingSetup),
    .errPrematureDone(errPrematureDone), .errCaptureNoReady(errCaptureNoReady),
    .errAddrMoved(errAddrMoved), .errCtrlMoved(errCtrlMoved), .waitCount(waitCount),
    .waitValid(waitValid), .histZero(histZero), .histOne(histOne), .histTwo(histTwo),
    .histMany(histMany), .mixedCount(mixedCount)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int satWait(input int w);
    return (w > 255) ? 255 : w;
  endfunction

  // Monitor: pops expected wait counts as the design reports them (R7).
  always @(negedge clk) begin
    if (rstN && waitValid) begin
      if (expQ.size() == 0) begin
        chk("R7/R11 unexpected valid", 1, 0);
      end else begin
        chk("R7 wait count", int'(waitCount), expQ.pop_front());
      end
    end
  end

  task automatic idle(input int n);
    sel = 1'b0; enable = 1'b0; ready = 1'b0; capture = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // One complete transfer; leaves sel high so a following call is adjacent.
  task automatic xfer(input int a, input bit wr, input int waits, input bit capAll);
    sel = 1'b1; enable = 1'b0; ready = 1'b0; capture = 1'b0;
    addr = ADDR_W'(a); write = wr;
    @(negedge clk);
    enable = 1'b1; capture = capAll;
    for (int i = 0; i < waits; i++) @(negedge clk);
    ready = 1'b1; capture = capAll | !wr;
    expQ.push_back(satWait(waits));
    @(negedge clk);
    enable = 1'b0; ready = 1'b0; capture = 1'b0;
  endtask

  task automatic chkErr(input string req, input int s, input int p, input int c,
                        input int a, input int w);
    chk({req, " missing-setup flag"}, int'(errMissingSetup), s);
    chk({req, " premature flag"}, int'(errPrematureDone), p);
    chk({req, " capture flag"}, int'(errCaptureNoReady), c);
    chk({req, " address flag"}, int'(errAddrMoved), a);
    chk({req, " control flag"}, int'(errCtrlMoved), w);
  endtask

  task automatic chkHist(input string req, input int h0, input int h1, input int h2,
                         input int hm, input int mx);
    chk({req, " bin0"}, int'(histZero), h0);
    chk({req, " bin1"}, int'(histOne), h1);
    chk({req, " bin2"}, int'(histTwo), h2);
    chk({req, " binMany"}, int'(histMany), hm);
    chk({req, " mixed"}, int'(mixedCount), mx);
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog R1..R11 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chkErr("R1 in reset", 0, 0, 0, 0, 0);
    chkHist("R1 in reset", 0, 0, 0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    chkErr("R1 after release", 0, 0, 0, 0, 0);
    chk("R1 valid low", int'(waitValid), 0);

    // R7 R8: isolated transfers of 0, 1, 2, 5 waits; read capture on ready (R4 legal)
    xfer(16'h010, 1'b1, 0, 1'b0); idle(2);
    xfer(16'h020, 1'b0, 1, 1'b0); idle(2);
    xfer(16'h030, 1'b0, 2, 1'b0); idle(2);
    xfer(16'h040, 1'b1, 5, 1'b0); idle(2);
    chkHist("R8 isolated", 1, 1, 1, 1, 0);

    // R9: adjacent chain 0,0,3,3,1 then a gap then 2
    xfer(16'h100, 1'b0, 0, 1'b0);
    xfer(16'h104, 1'b1, 0, 1'b0);
    xfer(16'h108, 1'b0, 3, 1'b0);
    xfer(16'h10c, 1'b1, 3, 1'b0);
    xfer(16'h110, 1'b0, 1, 1'b0);
    idle(1);
    xfer(16'h114, 1'b0, 2, 1'b0); idle(2);
    chkHist("R9 chain", 3, 2, 2, 3, 2);

    // R4: write-side capture ignored; R11: select-low activity ignored
    xfer(16'h200, 1'b1, 2, 1'b1);
    sel = 1'b0; write = 1'b1; enable = 1'b1; capture = 1'b1;
    for (int i = 0; i < 4; i++) begin ready = i[0]; @(negedge clk); end
    idle(2);
    chkHist("R11 idle noise", 3, 2, 3, 3, 2);
    chkErr("R4/R11 clean", 0, 0, 0, 0, 0);

    // R10: bin saturation at all-ones
    for (int i = 0; i < 20; i++) begin xfer(i * 4, 1'b0, 0, 1'b0); idle(1); end
    idle(1);
    chk("R10 bin0 saturates", int'(histZero), 15);

    // R7: wait count saturation
    xfer(16'h300, 1'b0, 300, 1'b0); idle(2);
    chk("R8 many bin", int'(histMany), 4);
    chk("R7 saturated count held", int'(waitCount), 255);
    chkErr("R2..R6 clean bus", 0, 0, 0, 0, 0);

    // R4: read capture during a wait cycle
    xfer(16'h400, 1'b0, 2, 1'b1); idle(2);
    chkErr("R4 capture", 0, 0, 1, 0, 0);

    // R5: address moves inside a transfer
    sel = 1'b1; enable = 1'b0; addr = 12'h500; write = 1'b0; @(negedge clk);
    enable = 1'b1; addr = 12'h504; ready = 1'b1; expQ.push_back(0); @(negedge clk);
    idle(2);
    chkErr("R5 address", 0, 0, 1, 1, 0);

    // R6: write moves inside a transfer
    sel = 1'b1; enable = 1'b0; addr = 12'h600; write = 1'b0; @(negedge clk);
    enable = 1'b1; write = 1'b1; ready = 1'b1; expQ.push_back(0); @(negedge clk);
    idle(2);
    chkErr("R6 control", 0, 0, 1, 1, 1);

    // R2: select and enable rise together
    sel = 1'b1; enable = 1'b1; ready = 1'b1; addr = 12'h700; write = 1'b1;
    expQ.push_back(0); @(negedge clk);
    idle(2);
    chkErr("R2 setup", 1, 0, 1, 1, 1);

    // R3: leave ACCESS while ready low
    sel = 1'b1; enable = 1'b0; addr = 12'h800; write = 1'b1; @(negedge clk);
    enable = 1'b1; ready = 1'b0; @(negedge clk);
    idle(1);
    chkErr("R3 premature", 1, 1, 1, 1, 1);
    idle(5);
    chkErr("R10 sticky", 1, 1, 1, 1, 1);

    // R1: reset clears everything
    rstN = 1'b0; @(negedge clk);
    chkErr("R1 re-reset", 0, 0, 0, 0, 0);
    chkHist("R1 re-reset", 0, 0, 0, 0, 0);
    rstN = 1'b1; @(negedge clk);
    chk("R7 all results seen", expQ.size(), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule